// File: doc/BRIEF.md
# Pointer-Passing Protocol Stage Queue

This block is a chain of protocol-processing stages for a packet offload pipeline. Stages never copy packet bytes to one another. Instead, each stage takes a 28-bit descriptor from its input table and looks at the header bytes the descriptor points to in an external packet buffer. It then leaves a modified descriptor in the table of the next stage. Each table is a small register array of `DEPTH` entries. An entry whose bits are all zero is free. Producers fill free entries, and a consumer writes the entry back to zero once it has finished with it.

Each stage runs a three-phase loop. It waits for work in its input table and processes the claimed descriptor over several cycles. It then saves the result into the next table and returns to waiting. The processing step reads `HDR_LEN` consecutive header bytes through one shared buffer read port. It drops the packet when the first byte equals a drop code, and otherwise strips `HDR_LEN` bytes from the front of the descriptor. A round-robin arbiter decides which stage owns the buffer port in each cycle.

The host fills the first table and drains the last one. When the final stage posts a descriptor, it raises a one-cycle interrupt that carries the descriptor and its table index.

Top module: `ptrq_pipe`

## Requirements
- R1: A descriptor is packed as bit 27 = buffer select (1 = receive buffer), bits 26:20 = slot, bits 19:11 = start offset, bits 10:0 = length. Read k of a stage addresses `{select, slot*512 + offset + k}` on the 17-bit buffer address.
- R2: A table entry of all zeros is empty. Writing zero into the input table starts no buffer read and posts nothing.
- R3: A stage with a claimed descriptor of length at least `HDR_LEN` issues `HDR_LEN` reads, one per grant, at consecutive byte addresses. It holds its request until it is granted, and it samples the read data in the cycle after the grant.
- R4: A forwarded descriptor leaves a stage with offset increased by `HDR_LEN`, length reduced by `HDR_LEN`, and slot and select unchanged. After the whole chain, offset has grown by `NSTAGE*HDR_LEN` and length has shrunk by the same amount.
- R5: If the first header byte a stage reads equals `DROP_CODE` (0xFF), the stage still completes its reads. It then clears its input entry and posts nothing.
- R6: A descriptor whose length is below `HDR_LEN` at a stage's input is dropped by that stage with no buffer read.
- R7: A stage scans its input table starting at the entry after the one it last consumed, wrapping around, and claims the first non-empty entry.
- R8: A stage posts into its output table at a rotating write index, and only into an empty entry. It clears its input entry in the same cycle. While that entry is occupied, the stage stalls in the save phase.
- R9: At most one stage is granted per cycle. A grant goes only to a requester, some requester is granted whenever any requests, and grants rotate so that no requester waits more than `NSTAGE-1` cycles.
- R10: When the last stage posts, `irq` is high for exactly one cycle, with `irq_desc` and `irq_idx` naming the posted descriptor. The output table entry at `irq_idx` then holds that descriptor.
- R11: After reset all tables are empty, no buffer read is issued and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Write one entry of the input table |
| host_wr_idx | input | 3 | Index of the input table entry to write |
| host_wr_desc | input | 28 | Descriptor written into the input table |
| host_rd_idx | input | 3 | Index of the output table entry to read |
| host_rd_desc | output | 28 | Content of the selected output table entry |
| host_clr_en | input | 1 | Free one entry of the output table |
| host_clr_idx | input | 3 | Index of the output table entry to free |
| buf_rd | output | 1 | Shared buffer read strobe |
| buf_addr | output | 17 | Buffer select and byte address of the read |
| buf_rdata | input | 8 | Read byte, valid the cycle after `buf_rd` |
| irq | output | 1 | One-cycle pulse when the last stage posts |
| irq_idx | output | 3 | Output table index just written |
| irq_desc | output | 28 | Descriptor just written |

## Verification
A single descriptor is sent through the chain to check the stripped offset and length and the exact sequence of buffer addresses. An all-zero write is sent to show that it starts nothing. A descriptor pointing at a slot filled with the drop code, and descriptors shorter than the header at the first and at the second stage, check that drops consume the input without posting and without extra reads. Writes placed around the wrap point of the input table, with stage 0 busy, separate scan-after-last from scan-from-zero. Back-to-back bursts make both stages contend for the buffer port. Leaving the output table undrained shows that the ninth result waits until one entry is freed.

// File: rtl/ptrq_pkg.sv
package ptrq_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SLOT_W  = 7;
   localparam int OFFS_W  = 9;
   localparam int LEN_W   = 11;
   localparam int BYTE_W  = 8;
   localparam int LOC_W   = SLOT_W + OFFS_W;
   localparam int BADDR_W = 1 + LOC_W;
   localparam int DESC_W  = 1 + SLOT_W + OFFS_W + LEN_W;

   typedef struct packed {
      logic              in_rx;
      logic [SLOT_W-1:0] slot;
      logic [OFFS_W-1:0] offs;
      logic [LEN_W-1:0]  len;
   } desc_t;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DATA  = 2'd2,
      ST_SAVE  = 2'd3
   } stage_st_e;
endpackage

// File: rtl/ptrq_table.sv
module ptrq_table
   import ptrq_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  desc_t            wr_data,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   output desc_t [DEPTH-1:0] ents
);
   timeunit 1ns;
   timeprecision 100ps;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ents[i] <= '0;
         end else if (clr_en && (clr_idx == IDX_W'(i))) begin
            ents[i] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            ents[i] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/ptrq_rr_arb.sv
module ptrq_rr_arb #(
   parameter int NREQ = 2,
   localparam int LAST_W = (NREQ > 1) ? $clog2(NREQ) : 1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   output logic [NREQ-1:0] gnt
);
   timeunit 1ns;
   timeprecision 100ps;

   if (NREQ == 1) begin : g_single
      assign gnt = req;
   end else begin : g_rr
      logic [LAST_W-1:0] last;
      logic [LAST_W-1:0] win;

      always_comb begin
         int c;
         win = last;
         gnt = '0;
         for (int k = NREQ; k >= 1; k--) begin
            c = (int'(last) + k) % NREQ;
            if (req[c]) win = LAST_W'(c);
         end
         if (|req) gnt[win] = 1'b1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) last <= LAST_W'(NREQ - 1);
         else if (|req) last <= win;
      end
   end
endmodule

// File: rtl/ptrq_stage.sv
module ptrq_stage
   import ptrq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int HDR_LEN = 2,
   parameter logic [BYTE_W-1:0] DROP_CODE = 8'hFF,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  desc_t [DEPTH-1:0]  in_ents,
   output logic               clr_en,
   output logic [IDX_W-1:0]   clr_idx,
   input  desc_t [DEPTH-1:0]  out_ents,
   output logic               post_en,
   output logic [IDX_W-1:0]   post_idx,
   output desc_t              post_data,
   output logic               rd_req,
   output logic [BADDR_W-1:0] rd_addr,
   input  logic               rd_gnt,
   input  logic [BYTE_W-1:0]  rd_data
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [LEN_W-1:0]  HL_LEN  = LEN_W'(HDR_LEN);
   localparam logic [OFFS_W-1:0] HL_OFFS = OFFS_W'(HDR_LEN);
   localparam logic [CNT_W-1:0]  HL_LAST = CNT_W'(HDR_LEN - 1);

   stage_st_e        st;
   desc_t            cur;
   desc_t            fwd;
   logic [IDX_W-1:0] cur_idx;
   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] wp;
   logic [IDX_W-1:0] pick;
   logic [CNT_W-1:0] cnt;
   logic             drop;
   logic             found;
   logic             room;

   // rotating scan: first non-empty entry after the last one consumed
   always_comb begin
      logic [IDX_W-1:0] cand;
      found = 1'b0;
      pick  = last_idx;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         cand = last_idx + IDX_W'(k + 1);
         if (in_ents[cand] != '0) begin
            found = 1'b1;
            pick  = cand;
         end
      end
   end

   always_comb begin
      fwd      = cur;
      fwd.offs = cur.offs + HL_OFFS;
      fwd.len  = cur.len - HL_LEN;
   end

   assign room      = (out_ents[wp] == '0);
   assign rd_req    = (st == ST_ISSUE);
   assign rd_addr   = {cur.in_rx, {cur.slot, cur.offs} + LOC_W'(cnt)};
   assign post_en   = (st == ST_SAVE) && !drop && room;
   assign clr_en    = (st == ST_SAVE) && (drop || room);
   assign clr_idx   = cur_idx;
   assign post_idx  = wp;
   assign post_data = fwd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_WAIT;
         cur      <= '0;
         cur_idx  <= '0;
         last_idx <= IDX_W'(DEPTH - 1);
         wp       <= '0;
         cnt      <= '0;
         drop     <= 1'b0;
      end else begin
         case (st)
            ST_WAIT: begin
               if (found) begin
                  cur      <= in_ents[pick];
                  cur_idx  <= pick;
                  last_idx <= pick;
                  cnt      <= '0;
                  drop     <= (in_ents[pick].len < HL_LEN);
                  st       <= (in_ents[pick].len < HL_LEN) ? ST_SAVE : ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (rd_gnt) st <= ST_DATA;
            end
            ST_DATA: begin
               if ((cnt == '0) && (rd_data == DROP_CODE)) drop <= 1'b1;
               if (cnt == HL_LAST) begin
                  st <= ST_SAVE;
               end else begin
                  cnt <= cnt + 1'b1;
                  st  <= ST_ISSUE;
               end
            end
            ST_SAVE: begin
               if (drop) begin
                  st <= ST_WAIT;
               end else if (room) begin
                  wp <= wp + 1'b1;
                  st <= ST_WAIT;
               end
            end
            default: st <= ST_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/ptrq_pipe.sv
module ptrq_pipe
   import ptrq_pkg::*;
#(
   parameter int NSTAGE = 2,
   parameter int DEPTH = 8,
   parameter int HDR_LEN = 2,
   parameter logic [BYTE_W-1:0] DROP_CODE = 8'hFF,
   localparam int IDX_W = $clog2(DEPTH)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr_en,
   input  logic [IDX_W-1:0]   host_wr_idx,
   input  logic [DESC_W-1:0]  host_wr_desc,
   input  logic [IDX_W-1:0]   host_rd_idx,
   output logic [DESC_W-1:0]  host_rd_desc,
   input  logic               host_clr_en,
   input  logic [IDX_W-1:0]   host_clr_idx,
   output logic               buf_rd,
   output logic [BADDR_W-1:0] buf_addr,
   input  logic [BYTE_W-1:0]  buf_rdata,
   output logic               irq,
   output logic [IDX_W-1:0]   irq_idx,
   output logic [DESC_W-1:0]  irq_desc
);
   timeunit 1ns;
   timeprecision 100ps;

   if (NSTAGE < 1) begin : g_bad_nstage
      $error("ptrq_pipe: NSTAGE must be at least 1");
   end
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("ptrq_pipe: DEPTH must be a power of two, at least 2");
   end
   if ((HDR_LEN < 1) || (HDR_LEN >= (1 << OFFS_W))) begin : g_bad_hdr
      $error("ptrq_pipe: HDR_LEN out of range");
   end

   desc_t [DEPTH-1:0]  tab_ents [NSTAGE+1];
   logic               st_post_en   [NSTAGE];
   logic [IDX_W-1:0]   st_post_idx  [NSTAGE];
   desc_t              st_post_data [NSTAGE];
   logic               st_clr_en    [NSTAGE];
   logic [IDX_W-1:0]   st_clr_idx   [NSTAGE];
   logic [BADDR_W-1:0] st_addr      [NSTAGE];
   logic [NSTAGE-1:0]  arb_req;
   logic [NSTAGE-1:0]  arb_gnt;

   for (genvar t = 0; t <= NSTAGE; t++) begin : g_tab
      if (t == 0) begin : g_in
         ptrq_table #(.DEPTH(DEPTH)) u_tab (
            .clk(clk), .rst_n(rst_n),
            .wr_en(host_wr_en), .wr_idx(host_wr_idx), .wr_data(desc_t'(host_wr_desc)),
            .clr_en(st_clr_en[0]), .clr_idx(st_clr_idx[0]),
            .ents(tab_ents[0]));
      end else if (t == NSTAGE) begin : g_out
         ptrq_table #(.DEPTH(DEPTH)) u_tab (
            .clk(clk), .rst_n(rst_n),
            .wr_en(st_post_en[t-1]), .wr_idx(st_post_idx[t-1]), .wr_data(st_post_data[t-1]),
            .clr_en(host_clr_en), .clr_idx(host_clr_idx),
            .ents(tab_ents[t]));
      end else begin : g_mid
         ptrq_table #(.DEPTH(DEPTH)) u_tab (
            .clk(clk), .rst_n(rst_n),
            .wr_en(st_post_en[t-1]), .wr_idx(st_post_idx[t-1]), .wr_data(st_post_data[t-1]),
            .clr_en(st_clr_en[t]), .clr_idx(st_clr_idx[t]),
            .ents(tab_ents[t]));
      end
   end

   for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
      ptrq_stage #(.DEPTH(DEPTH), .HDR_LEN(HDR_LEN), .DROP_CODE(DROP_CODE)) u_stage (
         .clk(clk), .rst_n(rst_n),
         .in_ents(tab_ents[s]),
         .clr_en(st_clr_en[s]), .clr_idx(st_clr_idx[s]),
         .out_ents(tab_ents[s+1]),
         .post_en(st_post_en[s]), .post_idx(st_post_idx[s]), .post_data(st_post_data[s]),
         .rd_req(arb_req[s]), .rd_addr(st_addr[s]),
         .rd_gnt(arb_gnt[s]), .rd_data(buf_rdata));
   end

   ptrq_rr_arb #(.NREQ(NSTAGE)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(arb_req), .gnt(arb_gnt));

   always_comb begin
      buf_addr = '0;
      for (int s = 0; s < NSTAGE; s++) begin
         if (arb_gnt[s]) buf_addr = buf_addr | st_addr[s];
      end
   end

   assign buf_rd       = |arb_gnt;
   assign host_rd_desc = tab_ents[NSTAGE][host_rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         irq_idx  <= '0;
         irq_desc <= '0;
      end else begin
         irq      <= st_post_en[NSTAGE-1];
         irq_idx  <= st_post_idx[NSTAGE-1];
         irq_desc <= st_post_data[NSTAGE-1];
      end
   end
endmodule

// File: rtl/ptrq_pipe_chk.sv
module ptrq_pipe_chk #(
   parameter int NREQ = 2
)(
   input logic            clk,
   input logic            rst_n,
   input logic [NREQ-1:0] req,
   input logic [NREQ-1:0] gnt,
   input logic            irq
);
   timeunit 1ns;
   timeprecision 100ps;

   // R9
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R9
   gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt & ~req) == '0));

   // R9
   no_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt));

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((($past(req) & ~$past(gnt))) & ~req) == '0));

   // R10
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   for (genvar i = 0; i < NREQ; i++) begin : g_wait
      logic [7:0] wcnt;
      always_ff @(posedge clk) begin
         if (!rst_n) wcnt <= '0;
         else if (req[i] && !gnt[i]) wcnt <= wcnt + 8'd1;
         else wcnt <= '0;
      end
      // R9
      wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req[i] && !gnt[i]) |-> (int'(wcnt) < NREQ - 1));
   end
endmodule

bind ptrq_pipe ptrq_pipe_chk #(.NREQ(NSTAGE)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(arb_req), .gnt(arb_gnt), .irq(irq));

// File: tb/ptrq_pipe_test.sv
module ptrq_pipe_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NST = 2;
   localparam int DEP = 8;
   localparam int HL  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [2:0]  host_wr_idx = '0;
   logic [27:0] host_wr_desc = '0;
   logic [2:0]  host_rd_idx;
   logic [2:0]  tb_rd_idx = '0;
   logic [27:0] host_rd_desc;
   logic        host_clr_en = 1'b0;
   logic [2:0]  host_clr_idx = '0;
   logic        buf_rd;
   logic [16:0] buf_addr;
   logic [7:0]  buf_rdata = '0;
   logic        irq;
   logic [2:0]  irq_idx;
   logic [27:0] irq_desc;

   int total = 0;
   int bad = 0;
   int irq_count = 0;
   int rd_count = 0;
   bit done = 1'b0;
   bit log_on = 1'b0;
   bit auto_clr = 1'b1;
   int man_req = 0;
   int man_done = 0;
   logic [2:0]  man_idx = '0;
   logic [27:0] exp_q [$];
   logic [16:0] rd_log [$];
   logic [2:0]  held_q [$];

   always #2.5 clk = ~clk;

   assign host_rd_idx = irq ? irq_idx : tb_rd_idx;

   ptrq_pipe #(.NSTAGE(NST), .DEPTH(DEP), .HDR_LEN(HL)) uut (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_desc(host_wr_desc),
      .host_rd_idx(host_rd_idx), .host_rd_desc(host_rd_desc),
      .host_clr_en(host_clr_en), .host_clr_idx(host_clr_idx),
      .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
      .irq(irq), .irq_idx(irq_idx), .irq_desc(irq_desc));

   function automatic logic [7:0] memf(input logic [16:0] a);
      if (a[15:9] == 7'd100) return 8'hFF;
      return (a[7:0] ^ 8'h3C) & 8'h7F;
   endfunction

   function automatic logic [27:0] mk(input logic sel, input int slot, input int offs, input int len);
      return {sel, 7'(slot), 9'(offs), 11'(len)};
   endfunction

   // reference model of the chain, from the requirements
   function automatic bit model(input logic [27:0] d, output logic [27:0] o);
      logic [15:0] loc;
      o = d;
      for (int s = 0; s < NST; s++) begin
         if (int'(o[10:0]) < HL) return 1'b0;
         loc = o[26:11];
         if (memf({o[27], loc}) == 8'hFF) return 1'b0;
         o[19:11] = o[19:11] + 9'(HL);
         o[10:0]  = o[10:0] - 11'(HL);
      end
      return 1'b1;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] idx, input logic [27:0] d);
      logic [27:0] o;
      if (d != '0 && model(d, o)) exp_q.push_back(o);
      @(negedge clk);
      host_wr_en   = 1'b1;
      host_wr_idx  = idx;
      host_wr_desc = d;
      @(negedge clk);
      host_wr_en   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: scoreboard pops, read logging, egress draining
   always @(negedge clk) begin
      if (rst_n) begin
         host_clr_en = 1'b0;
         if (buf_rd) begin
            rd_count++;
            if (log_on) rd_log.push_back(buf_addr);
         end
         if (irq) begin
            irq_count++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected result", 64'(irq_desc), 64'h0);
            end else begin
               logic [27:0] e;
               e = exp_q.pop_front();
               chk(irq_desc == e, "R4/R7 result descriptor", 64'(irq_desc), 64'(e));
            end
            chk(host_rd_desc == irq_desc, "R10 output entry content", 64'(host_rd_desc), 64'(irq_desc));
            if (auto_clr) begin
               host_clr_en  = 1'b1;
               host_clr_idx = irq_idx;
            end else begin
               held_q.push_back(irq_idx);
            end
         end else if (man_req != man_done) begin
            host_clr_en  = 1'b1;
            host_clr_idx = man_idx;
            man_done++;
         end
      end
   end

   always @(posedge clk) begin
      if (buf_rd) buf_rdata <= memf(buf_addr);
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int ic, rc;
      logic [16:0] base;
      repeat (5) @(negedge clk);
      // R11 reset state
      chk(irq == 1'b0, "R11 irq in reset", 64'(irq), 64'h0);
      chk(buf_rd == 1'b0, "R11 buf_rd in reset", 64'(buf_rd), 64'h0);
      for (int i = 0; i < DEP; i++) begin
         tb_rd_idx = 3'(i);
         #0.5;
         chk(host_rd_desc == '0, "R11 output table empty", 64'(host_rd_desc), 64'h0);
      end
      rst_n = 1'b1;
      idle(3);

      // R1 R3 R4 single packet, address sequence
      log_on = 1'b1;
      ic = irq_count;
      send(3'd0, mk(1'b1, 3, 10, 100));
      idle(60);
      log_on = 1'b0;
      chk(irq_count == ic + 1, "R4 single packet delivered", 64'(irq_count - ic), 64'd1);
      chk(rd_log.size() == NST * HL, "R3 read count", 64'(rd_log.size()), 64'(NST * HL));
      base = {1'b1, 16'(3 * 512 + 10)};
      for (int k = 0; k < NST * HL; k++) begin
         if (k < rd_log.size())
            chk(rd_log[k] == base + 17'(k), "R1 read address", 64'(rd_log[k]), 64'(base + 17'(k)));
      end

      // R2 zero entry is empty
      ic = irq_count; rc = rd_count;
      send(3'd1, 28'h0);
      idle(40);
      chk(rd_count == rc, "R2 zero write reads", 64'(rd_count - rc), 64'd0);
      chk(irq_count == ic, "R2 zero write results", 64'(irq_count - ic), 64'd0);

      // R5 drop code in first header byte
      ic = irq_count; rc = rd_count;
      send(3'd2, mk(1'b0, 100, 5, 50));
      idle(50);
      chk(irq_count == ic, "R5 dropped packet posts nothing", 64'(irq_count - ic), 64'd0);
      chk(rd_count == rc + HL, "R5 drop still reads header once", 64'(rd_count - rc), 64'(HL));

      // R6 runt at stage 0 and at stage 1
      ic = irq_count; rc = rd_count;
      send(3'd3, mk(1'b1, 7, 0, 1));
      idle(40);
      chk(rd_count == rc, "R6 runt no reads", 64'(rd_count - rc), 64'd0);
      rc = rd_count;
      send(3'd4, mk(1'b1, 8, 20, 3));
      idle(50);
      chk(rd_count == rc + HL, "R6 runt at second stage reads", 64'(rd_count - rc), 64'(HL));
      chk(irq_count == ic, "R6 runts post nothing", 64'(irq_count - ic), 64'd0);

      // R7 scan order across the wrap point
      ic = irq_count;
      send(3'd6, mk(1'b0, 20, 0, 200));
      send(3'd7, mk(1'b1, 21, 4, 300));
      send(3'd0, mk(1'b0, 22, 8, 400));
      send(3'd1, mk(1'b1, 23, 12, 500));
      idle(150);
      chk(irq_count == ic + 4, "R7 wrap packets delivered", 64'(irq_count - ic), 64'd4);

      // R9 burst with both stages contending
      ic = irq_count;
      for (int i = 0; i < 6; i++) send(3'(2 + i), mk(1'(i), 30 + i, 3 * i, 64 + 17 * i));
      idle(200);
      chk(irq_count == ic + 6, "R9 burst delivered", 64'(irq_count - ic), 64'd6);

      // R8 full output table stalls the last stage
      auto_clr = 1'b0;
      ic = irq_count;
      for (int i = 0; i < 9; i++) begin
         send(3'(i), mk(1'b1, 40 + i, i, 80 + i));
         idle(12);
      end
      idle(200);
      chk(irq_count == ic + 8, "R8 stall at full table", 64'(irq_count - ic), 64'd8);
      if (held_q.size() > 0) begin
         man_idx = held_q.pop_front();
         man_req++;
      end
      idle(60);
      chk(irq_count == ic + 9, "R8 resume after one entry freed", 64'(irq_count - ic), 64'd9);
      auto_clr = 1'b1;
      while (held_q.size() > 0) begin
         man_idx = held_q.pop_front();
         man_req++;
         idle(3);
      end
      idle(10);
      chk(exp_q.size() == 0, "R4 all expected results seen", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule